// File: doc/BRIEF.md
# Buffered Program Sequencer

This block sequences the write-to-buffer program flow of a parallel NOR flash command engine. From read-array mode, a bus write whose low byte is 0xE8 opens the sequence and sets the ready bit of the status register at once. The next bus write supplies a word count N, which is cut down to the device width (or the bank width when no device width is configured). Exactly N+1 further writes then go straight through to the array, and one last write must carry the confirm code 0xD0.

While the sequence is open, `busy` is high and bus reads return the status register copied into every device lane of the bank, in place of array data. A good confirm closes the sequence with ready set. Any other confirm value aborts to read-array mode and flags a program error. When `ro_lock` is high, data writes are dropped and flag the same error, but they still count down.

States and transitions: `ST_ARRAY` (read array) goes to `ST_COUNT` on the open command. `ST_COUNT` goes to `ST_DATA` on any write, which loads the count. `ST_DATA` stays put while the remaining count is not zero, and goes to `ST_CONFIRM` on the write made when it is zero. `ST_CONFIRM` goes back to `ST_ARRAY` on any write, either completing or aborting.

Top module: `bufwr_seq`

## Requirements
- R1: After reset, `busy` is 0, `stat_reg` is 0x00 and `bus_rdata` equals `arr_rdata`.
- R2: In read-array mode, a write with low byte 0xE8 sets status bit 7 and raises `busy` on the next cycle. Any other write value there leaves `busy`, `stat_reg` and `arr_we` unchanged.
- R3: The count write keeps only its low CNT_W bits: DEV_BYTES*8 bits, or BANK_BYTES*8 when DEV_BYTES is 0. With the defaults this is 16 bits, so 0x0001_0000 counts as 0.
- R4: With a latched count N, exactly the next N+1 writes assert `arr_we` in their own cycle, passing `wr_addr` and `wr_data` through unchanged. The write after them is the confirm and does not assert `arr_we`.
- R5: A confirm write with low byte 0xD0 returns the block to read-array mode, drops `busy` and sets status bit 7.
- R6: A confirm write with any other low byte also returns to read-array mode and drops `busy`, but sets status bit 4 (program error). Status bits stay set until reset.
- R7: While `ro_lock` is high, data-phase writes do not assert `arr_we` and set status bit 4. They still count toward the N+1 items.
- R8: While `busy` is high, `bus_rdata` carries the status byte at every lane base (every DEV_BYTES bytes, or every 2 bytes when DEV_BYTES is 0) with zeros elsewhere. With the defaults this is {8'h00, stat, 8'h00, stat}.
- R9: A count of 0 gives exactly one data write before the confirm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8*BANK_BYTES | Bus write data |
| ro_lock | input | 1 | Array is read-only |
| arr_rdata | input | 8*BANK_BYTES | Array read data |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8*BANK_BYTES | Array write data |
| bus_rdata | output | 8*BANK_BYTES | Bus read data: array data or replicated status |
| stat_reg | output | 8 | Status register |
| busy | output | 1 | Buffered sequence in progress |

## Verification
The hardest case to reach is the boundary between the last data item and the confirm. The same write strobe is stored in one state and treated as a command in the next, and an off-by-one in the countdown only shows up there. The stimulus loads counts whose upper bits would be non-zero if they were not masked. It then issues exactly N+1 writes that must each pulse `arr_we` and a further write that must not. The zero-count case is combined with an abort, so that the single-item path and the error path are covered in one sequence.

// File: rtl/bufwr_pkg.sv
package bufwr_pkg;

    typedef enum logic [1:0] {
        ST_ARRAY   = 2'd0,
        ST_COUNT   = 2'd1,
        ST_DATA    = 2'd2,
        ST_CONFIRM = 2'd3
    } bufwr_state_t;

    localparam logic [7:0] OP_BUF_OPEN = 8'hE8;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam int         BIT_READY   = 7;
    localparam int         BIT_PGMERR  = 4;

endpackage

// File: rtl/bufwr_count.sv
module bufwr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] rem;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (load) begin
            rem <= load_val;
        end else if (dec && rem != '0) begin
            rem <= rem - 1'b1;
        end
    end

    assign last = (rem == '0);
endmodule

// File: rtl/bufwr_status.sv
module bufwr_status #(
    parameter int BANK_BYTES = 4,
    parameter int DEV_BYTES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_rdy,
    input  logic                    set_err,
    output logic [7:0]              stat,
    output logic [8*BANK_BYTES-1:0] stat_word
);
    import bufwr_pkg::*;

    localparam int LANE = (DEV_BYTES != 0) ? DEV_BYTES : 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= 8'h00;
        end else begin
            if (set_rdy) stat[BIT_READY]  <= 1'b1;
            if (set_err) stat[BIT_PGMERR] <= 1'b1;
        end
    end

    for (genvar b = 0; b < BANK_BYTES; b++) begin : g_lane
        if (b % LANE == 0) begin : g_copy
            assign stat_word[8*b +: 8] = stat;
        end else begin : g_zero
            assign stat_word[8*b +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/bufwr_seq.sv
module bufwr_seq #(
    parameter int BANK_BYTES = 4,
    parameter int DEV_BYTES  = 2,
    parameter int ADDR_W     = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [8*BANK_BYTES-1:0] wr_data,
    input  logic                    ro_lock,
    input  logic [8*BANK_BYTES-1:0] arr_rdata,
    output logic                    arr_we,
    output logic [ADDR_W-1:0]       arr_addr,
    output logic [8*BANK_BYTES-1:0] arr_wdata,
    output logic [8*BANK_BYTES-1:0] bus_rdata,
    output logic [7:0]              stat_reg,
    output logic                    busy
);
    import bufwr_pkg::*;

    localparam int CNT_W = (DEV_BYTES != 0) ? 8*DEV_BYTES : 8*BANK_BYTES;

    bufwr_state_t state, state_nx;
    logic set_rdy, set_err, cnt_load, cnt_dec, cnt_last;
    logic [8*BANK_BYTES-1:0] stat_word;
    logic is_open, is_confirm;

    assign is_open    = (wr_data[7:0] == OP_BUF_OPEN);
    assign is_confirm = (wr_data[7:0] == OP_CONFIRM);

    bufwr_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (wr_data[CNT_W-1:0]),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    bufwr_status #(.BANK_BYTES(BANK_BYTES), .DEV_BYTES(DEV_BYTES)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_rdy   (set_rdy),
        .set_err   (set_err),
        .stat      (stat_reg),
        .stat_word (stat_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ARRAY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARRAY:   if (wr_en && is_open)  state_nx = ST_COUNT;
            ST_COUNT:   if (wr_en)             state_nx = ST_DATA;
            ST_DATA:    if (wr_en && cnt_last) state_nx = ST_CONFIRM;
            ST_CONFIRM: if (wr_en)             state_nx = ST_ARRAY;
        endcase
    end

    always_comb begin
        set_rdy  = 1'b0;
        set_err  = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        arr_we   = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_ARRAY: begin
                busy    = 1'b0;
                set_rdy = wr_en && is_open;
            end
            ST_COUNT: begin
                cnt_load = wr_en;
            end
            ST_DATA: begin
                cnt_dec = wr_en;
                arr_we  = wr_en && !ro_lock;
                set_err = wr_en && ro_lock;
            end
            ST_CONFIRM: begin
                set_rdy = wr_en && is_confirm;
                set_err = wr_en && !is_confirm;
            end
        endcase
    end

    assign arr_addr  = wr_addr;
    assign arr_wdata = wr_data;
    assign bus_rdata = busy ? stat_word : arr_rdata;
endmodule

// File: rtl/bufwr_chk.sv
module bufwr_chk #(
    parameter int BANK_BYTES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [8*BANK_BYTES-1:0] wr_data,
    input logic                    ro_lock,
    input logic                    arr_we,
    input logic [8*BANK_BYTES-1:0] bus_rdata,
    input logic [7:0]              stat_reg,
    input logic                    busy
);
    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (busy && wr_en)); // R4

    AST_OPEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && wr_data[7:0] == 8'hE8) |=> (busy && stat_reg[7])); // R2

    AST_IDLE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(wr_en && wr_data[7:0] == 8'hE8)) |=> (!busy && $stable(stat_reg))); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_reg[4] |=> stat_reg[4]); // R6

    AST_RO_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ro_lock |-> !arr_we); // R7

    AST_EXIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wr_en)); // R5

    AST_RD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bus_rdata[7:0] == stat_reg)); // R8
endmodule

bind bufwr_seq bufwr_chk #(.BANK_BYTES(BANK_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ro_lock   (ro_lock),
    .arr_we    (arr_we),
    .bus_rdata (bus_rdata),
    .stat_reg  (stat_reg),
    .busy      (busy)
);

// File: tb/test_bufwr_seq.sv
module test_bufwr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ro_lock = 1'b0;
    logic [31:0] arr_rdata = 32'hCAFE_1234;
    logic        arr_we;
    logic [11:0] arr_addr;
    logic [31:0] arr_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  stat_reg;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bufwr_seq i_bufwr_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ro_lock(ro_lock), .arr_rdata(arr_rdata),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .bus_rdata(bus_rdata), .stat_reg(stat_reg), .busy(busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; ro_lock = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one bus write; array strobe checked in the write cycle itself
    task automatic bus_write(input string tag, input logic [11:0] a, input logic [31:0] d,
                             input logic exp_we);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1;
        check({tag, " arr_we"}, {31'd0, arr_we}, {31'd0, exp_we});
        if (exp_we) begin
            check({tag, " arr_addr"}, {20'd0, arr_addr}, {20'd0, a});
            check({tag, " arr_wdata"}, arr_wdata, d);
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 stat", {24'd0, stat_reg}, 32'h00);
        check("R1 rdata", bus_rdata, 32'hCAFE_1234);
    endtask

    task automatic t_idle_ignore();
        do_reset();
        bus_write("R2 idle 55", 12'h010, 32'h0000_0055, 1'b0);
        bus_write("R2 idle D0", 12'h011, 32'h0000_00D0, 1'b0);
        #2;
        check("R2 idle busy", {31'd0, busy}, 32'd0);
        check("R2 idle stat", {24'd0, stat_reg}, 32'h00);
    endtask

    task automatic t_normal();
        do_reset();
        bus_write("R2 open", 12'h000, 32'h0000_00E8, 1'b0);
        #2;
        check("R2 busy", {31'd0, busy}, 32'd1);
        check("R2 ready", {24'd0, stat_reg}, 32'h80);
        check("R8 rdata", bus_rdata, 32'h0080_0080);
        bus_write("R3 count", 12'h000, 32'hABCD_0002, 1'b0);
        for (int k = 0; k < 3; k++)
            bus_write("R4 data", 12'h100 + 12'(k), 32'h1111_0000 + 32'(k), 1'b1);
        #2;
        check("R8 rdata data", bus_rdata, 32'h0080_0080);
        bus_write("R4 confirm no we", 12'h100, 32'h0000_00D0, 1'b0);
        #2;
        check("R5 busy", {31'd0, busy}, 32'd0);
        check("R5 stat", {24'd0, stat_reg}, 32'h80);
        check("R5 rdata", bus_rdata, 32'hCAFE_1234);
    endtask

    task automatic t_zero_abort();
        do_reset();
        bus_write("R9 open", 12'h000, 32'h0000_00E8, 1'b0);
        bus_write("R3 masked count", 12'h000, 32'h0001_0000, 1'b0);
        bus_write("R9 single", 12'h020, 32'h5A5A_A5A5, 1'b1);
        bus_write("R9 next is confirm", 12'h021, 32'h0000_0012, 1'b0);
        #2;
        check("R6 busy", {31'd0, busy}, 32'd0);
        check("R6 stat", {24'd0, stat_reg}, 32'h90);
    endtask

    task automatic t_readonly();
        do_reset();
        ro_lock = 1'b1;
        bus_write("R7 open", 12'h000, 32'h0000_00E8, 1'b0);
        bus_write("R7 count", 12'h000, 32'h0000_0001, 1'b0);
        bus_write("R7 data0", 12'h040, 32'h0000_0001, 1'b0);
        #2;
        check("R7 err", {24'd0, stat_reg}, 32'h90);
        bus_write("R7 data1", 12'h041, 32'h0000_0002, 1'b0);
        #2;
        check("R7 still busy", {31'd0, busy}, 32'd1);
        bus_write("R7 confirm", 12'h041, 32'h0000_00D0, 1'b0);
        #2;
        check("R7 done", {31'd0, busy}, 32'd0);
        ro_lock = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle_ignore();
        t_normal();
        t_zero_abort();
        t_readonly();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule